// File: doc/BRIEF.md
# Cache-Line Zeroing Engine

This block carries out one request to clear a whole cache line to zero. It takes the request's address and rounds it down to the start of a line. The line size can be 32, 64 or 128 bytes. Before any data moves, it checks whether an outstanding load-reserve address lies inside that same line. If it does, the block raises a one-cycle pulse so that the reservation holder can cancel it.

The engine then writes 64-bit zeros across the line, one beat per valid/ready handshake, from the lowest address upward. A one-cycle completion pulse follows the last accepted beat. A long-form request can carry a 2-bit mode field. When that field holds the code 1, the line is cut to 32 bytes whatever the size select says.

Top module: `zline_engine`

## Requirements
- R1: The first write beat goes to the request address with its low log2(line bytes) bits cleared.
- R2: `req_size_sel` chooses the line size: 0 gives 32 bytes, 1 gives 64 bytes, and 2 or 3 give 128 bytes.
- R3: If `req_long` is 1 and `req_mode_fld` equals 2'b01, the line size is 32 bytes. Any other mode value, or `req_long` at 0, leaves the size as R2 gives it.
- R4: The burst is line_bytes/8 beats. Each beat carries `wr_data` equal to zero, and each beat's address is 8 higher than the one before.
- R5: `rsv_kill` pulses for exactly one cycle when `rsv_addr`, with its low log2(line bytes) bits cleared, equals the aligned line address. Otherwise it stays low for the whole request.
- R6: The reservation check happens in the cycle after the request is accepted. No write beat is valid in that cycle or earlier.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_addr` stays unchanged.
- R8: `done` is high for one cycle, in the cycle right after the last beat is accepted. `req_ready` is high again in the cycle after that.
- R9: `req_ready` is low from acceptance until the end of `done`. A `req_valid` in that window is ignored and does not change the burst in progress.
- R10: After reset, `req_ready` is 1 and `wr_valid`, `rsv_kill` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken when both high |
| req_addr | input | ADDR_W | Any byte address inside the target line |
| req_size_sel | input | 2 | Line size select (R2) |
| req_long | input | 1 | Long-form request, enables the mode override |
| req_mode_fld | input | 2 | Mode field, code 1 forces a 32-byte line |
| rsv_addr | input | ADDR_W | Current load-reserve address |
| rsv_kill | output | 1 | Pulse: cancel the reservation |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W | Beat address |
| wr_data | output | 64 | Beat data, always zero |
| done | output | 1 | Pulse after the last beat |

## Verification
A wrong captured line size shows up as a wrong beat count, so the error is visible at the point where `done` should have appeared. A wrong alignment mask shows up either in the very first `wr_addr` or in `rsv_kill` during the check cycle, one cycle after acceptance. A beat counter that slips under back-pressure repeats an address or skips one within a beat of the stall. A state machine stuck busy keeps `req_ready` low past the `done` cycle.

// File: rtl/zline_pkg.sv
package zline_pkg;
  typedef enum logic [1:0] {
    ZL_IDLE  = 2'd0,
    ZL_CHECK = 2'd1,
    ZL_BURST = 2'd2,
    ZL_DONE  = 2'd3
  } zl_state_e;

  localparam logic [1:0] ZL_OVR_CODE = 2'b01;
endpackage

// File: rtl/zline_size_sel.sv
module zline_size_sel #(
  parameter int MIN_LOG2   = 5,
  parameter int MAX_LOG2   = 7,
  parameter int FORCE_LOG2 = 5,
  parameter int SEL_W      = 2,
  parameter int LOG_W      = 3
) (
  input  logic [SEL_W-1:0] size_sel,
  input  logic             long_form,
  input  logic [1:0]       mode_fld,
  output logic [LOG_W-1:0] line_log2
);
  import zline_pkg::*;

  logic [LOG_W:0] raw_log2;

  always_comb begin
    raw_log2 = (LOG_W+1)'(MIN_LOG2) + (LOG_W+1)'(size_sel);
    if (raw_log2 > (LOG_W+1)'(MAX_LOG2)) begin
      raw_log2 = (LOG_W+1)'(MAX_LOG2);
    end
    if (long_form && (mode_fld == ZL_OVR_CODE)) begin
      line_log2 = LOG_W'(FORCE_LOG2);
    end else begin
      line_log2 = raw_log2[LOG_W-1:0];
    end
  end
endmodule

// File: rtl/zline_rsv_cmp.sv
module zline_rsv_cmp #(
  parameter int ADDR_W = 32,
  parameter int LOG_W  = 3
) (
  input  logic [ADDR_W-1:0] rsv_addr,
  input  logic [ADDR_W-1:0] line_base,
  input  logic [LOG_W-1:0]  line_log2,
  output logic              hit
);
  logic [ADDR_W-1:0] line_mask;

  always_comb begin
    line_mask = {ADDR_W{1'b1}} << line_log2;
    hit       = ((rsv_addr & line_mask) == line_base);
  end
endmodule

// File: rtl/zline_beat_ctr.sv
module zline_beat_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] idx,
  output logic             is_last
);
  logic [CNT_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr | adv;
    idx_d  = clr ? '0 : idx + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_d;
    end
  end

  assign is_last = (idx == last_idx);
endmodule

// File: rtl/zline_engine.sv
module zline_engine #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  parameter int MIN_LOG2   = 5,
  parameter int MAX_LOG2   = 7,
  parameter int FORCE_LOG2 = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size_sel,
  input  logic                    req_long,
  input  logic [1:0]              req_mode_fld,
  input  logic [ADDR_W-1:0]       rsv_addr,
  output logic                    rsv_kill,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [BEAT_BYTES*8-1:0] wr_data,
  output logic                    done
);
  import zline_pkg::*;

  localparam int DATA_W    = BEAT_BYTES * 8;
  localparam int BEAT_LOG2 = $clog2(BEAT_BYTES);
  localparam int LOG_W     = $clog2(MAX_LOG2 + 1);
  localparam int CNT_W     = MAX_LOG2 - BEAT_LOG2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  zl_state_e         state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LOG_W-1:0]  log2_q, log2_d;
  logic [CNT_W-1:0]  last_q, last_d;
  logic              cap_en;
  logic [LOG_W-1:0]  req_log2;
  logic [ADDR_W-1:0] req_mask;
  logic [CNT_W:0]    nbeats;
  logic              rsv_hit;
  logic [CNT_W-1:0]  beat_idx;
  logic              beat_last, beat_adv, beat_clr;

  zline_size_sel #(
    .MIN_LOG2  (MIN_LOG2),
    .MAX_LOG2  (MAX_LOG2),
    .FORCE_LOG2(FORCE_LOG2),
    .SEL_W     (2),
    .LOG_W     (LOG_W)
  ) u_size (
    .size_sel (req_size_sel),
    .long_form(req_long),
    .mode_fld (req_mode_fld),
    .line_log2(req_log2)
  );

  zline_rsv_cmp #(
    .ADDR_W(ADDR_W),
    .LOG_W (LOG_W)
  ) u_rsv (
    .rsv_addr (rsv_addr),
    .line_base(base_q),
    .line_log2(log2_q),
    .hit      (rsv_hit)
  );

  zline_beat_ctr #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (beat_clr),
    .adv     (beat_adv),
    .last_idx(last_q),
    .idx     (beat_idx),
    .is_last (beat_last)
  );

  always_comb begin
    req_mask = {ADDR_W{1'b1}} << req_log2;
    nbeats   = (CNT_W+1)'(1) << (req_log2 - LOG_W'(BEAT_LOG2));
    base_d   = req_addr & req_mask;
    log2_d   = req_log2;
    last_d   = CNT_W'(nbeats - (CNT_W+1)'(1));
  end

  always_comb begin
    req_ready = (state_q == ZL_IDLE);
    wr_valid  = (state_q == ZL_BURST);
    rsv_kill  = (state_q == ZL_CHECK) && rsv_hit;
    done      = (state_q == ZL_DONE);
    wr_addr   = base_q + (ADDR_W'(beat_idx) << BEAT_LOG2);
    wr_data   = {DATA_W{1'b0}};
    cap_en    = req_ready && req_valid;
    beat_clr  = (state_q == ZL_CHECK);
    beat_adv  = wr_valid && wr_ready;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ZL_IDLE:  if (req_valid) state_d = ZL_CHECK;
      ZL_CHECK: state_d = ZL_BURST;
      ZL_BURST: if (wr_ready && beat_last) state_d = ZL_DONE;
      ZL_DONE:  state_d = ZL_IDLE;
      default:  state_d = ZL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ZL_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q <= '0;
      log2_q <= LOG_W'(MIN_LOG2);
      last_q <= '0;
    end else if (cap_en) begin
      base_q <= base_d;
      log2_q <= log2_d;
      last_q <= last_d;
    end
  end

  assert_size_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready) |=> (log2_q >= LOG_W'(MIN_LOG2) && log2_q <= LOG_W'(MAX_LOG2)));

  assert_kill_no_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsv_kill |-> !wr_valid);

  assert_kill_then_burst_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsv_kill |=> (wr_valid && !rsv_kill));

  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

  assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid && wr_ready) |=> (wr_valid ? (wr_addr == $past(wr_addr) + ADDR_W'(BEAT_BYTES)) : done));

  assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> $past(wr_valid && wr_ready));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({req_ready, wr_valid, done, rsv_kill}));
endmodule

// File: tb/zline_engine_tb.sv
module zline_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_long, wr_ready;
  logic [31:0] req_addr, rsv_addr;
  logic [1:0]  req_size_sel, req_mode_fld;
  logic        req_ready, rsv_kill, wr_valid, done;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  zline_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size_sel(req_size_sel), .req_long(req_long), .req_mode_fld(req_mode_fld),
    .rsv_addr(rsv_addr), .rsv_kill(rsv_kill),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line size from R2 and R3
  function automatic int exp_bytes(input logic [1:0] sel, input logic lng, input logic [1:0] fld);
    if (lng && fld == 2'b01) return 32;
    case (sel)
      2'd0: return 32;
      2'd1: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic run_req(input logic [31:0] addr, input logic [1:0] sel, input logic lng,
                         input logic [1:0] fld, input logic [31:0] rsv,
                         input bit stall, input bit poke);
    int          nb   = exp_bytes(sel, lng, fld);
    logic [31:0] base = addr & ~(32'(nb) - 32'd1);
    logic        kill = ((rsv & ~(32'(nb) - 32'd1)) == base);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_size_sel = sel; req_long = lng;
    req_mode_fld = fld; rsv_addr = rsv; wr_ready = 1'b0;
    chk(req_ready == 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsv_kill == kill, "R5 reservation kill", 64'(rsv_kill), 64'(kill));
    chk(wr_valid == 1'b0, "R6 no write during check", 64'(wr_valid), 64'd0);
    @(negedge clk);
    chk(rsv_kill == 1'b0, "R5 kill is one cycle", 64'(rsv_kill), 64'd0);
    for (int k = 0; k < nb / 8; k++) begin
      if (poke) begin
        req_valid = 1'b1; req_addr = 32'hDEAD_BEE0; req_size_sel = 2'd0;
        chk(req_ready == 1'b0, "R9 busy not ready", 64'(req_ready), 64'd0);
      end
      chk(wr_valid == 1'b1, "R4 beat valid", 64'(wr_valid), 64'd1);
      if (k == 0) chk(wr_addr == base, "R1 aligned base", 64'(wr_addr), 64'(base));
      else chk(wr_addr == base + 32'(8 * k), "R4 beat address", 64'(wr_addr), 64'(base + 32'(8 * k)));
      chk(wr_data == 64'd0, "R4 zero data", wr_data, 64'd0);
      if (stall && (k % 2 == 1)) begin
        wr_ready = 1'b0;
        @(negedge clk);
        chk(wr_valid == 1'b1 && wr_addr == base + 32'(8 * k), "R7 hold under stall",
            64'(wr_addr), 64'(base + 32'(8 * k)));
      end
      wr_ready = 1'b1;
      @(negedge clk);
    end
    wr_ready = 1'b0; req_valid = 1'b0;
    chk(done == 1'b1, "R8 done after last beat (R2 R3 beat count)", 64'(done), 64'd1);
    chk(wr_valid == 1'b0, "R4 burst length", 64'(wr_valid), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R8 ready again", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; wr_ready = 1'b0; req_addr = '0; rsv_addr = '1;
    req_size_sel = '0; req_long = 1'b0; req_mode_fld = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && wr_valid == 1'b0 && rsv_kill == 1'b0 && done == 1'b0,
        "R10 reset state", {60'd0, req_ready, wr_valid, rsv_kill, done}, 64'h8);
  endtask

  initial begin
    t_reset();
    run_req(32'h1000_0047, 2'd0, 1'b0, 2'd0, 32'h5000_0000, 1'b0, 1'b0); // R2 32B, no kill
    run_req(32'h2000_00FF, 2'd1, 1'b0, 2'd0, 32'h2000_00C8, 1'b0, 1'b0); // R2 64B, R5 kill
    run_req(32'h3000_01F3, 2'd2, 1'b0, 2'd0, 32'h3000_01FF, 1'b1, 1'b1); // R7 R9 128B
    run_req(32'h3000_0005, 2'd3, 1'b0, 2'd0, 32'h3000_0080, 1'b0, 1'b0); // R2 code 3
    run_req(32'h4000_0077, 2'd2, 1'b1, 2'd1, 32'h4000_0050, 1'b0, 1'b0); // R3 override, no kill
    run_req(32'h4000_0077, 2'd1, 1'b0, 2'd1, 32'h4000_0050, 1'b1, 1'b0); // R3 short form no effect
    run_req(32'h4000_0077, 2'd1, 1'b1, 2'd2, 32'h4000_0050, 1'b0, 1'b0); // R3 other code no effect
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule